// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a small serial EEPROM that sits on a three-wire bus. The bus carries a select line, a shift clock and a serial data input, and the block drives a serial data output with an enable. The block runs on a fast system clock. It passes the three bus lines through a synchronizer and finds their edges there, so the shift clock is never used as a clock. The block holds 1024 bits of storage. A strap input chooses one of two views of that storage: 128 bytes, or 64 sixteen-bit words.

A host selects the device and then clocks in an instruction. The instruction is a start bit, a two-bit opcode and an address, followed by data when the instruction writes. The block decodes seven instructions:

- read
- write one location
- erase one location to all ones
- fill every location with one pattern
- erase everything
- unlock programming
- lock programming

Every programming operation starts a self-timed cycle. The cycle length is a parameter counted in system clocks. While the cycle runs, the host can toggle the select line to poll a ready/busy flag on the data output.

Top module: `sep_eeprom`

## Requirements
- R1: While select is high, zeros clocked before the first 1 are ignored. That first 1 is the start bit. It is followed, MSB first, by a 2-bit opcode and then the address field: 7 bits when `wide_i` is low, 6 bits when it is high. Each bit is taken on a rising shift-clock edge.
- R2: Opcode 10 reads, 01 writes and 11 erases one location. Opcode 00 picks a special action from the two top address bits, and the remaining address bits must still be shifted in. The special actions are 11 unlock, 00 lock, 10 erase-all and 01 fill-all.
- R3: A read enables the output once the last address bit has been taken. The output first drives one 0 bit. It then drives the word MSB first (8 bits narrow, 16 bits wide), and changes only after rising shift-clock edges.
- R4: If clocking continues after the last bit of a word, a read goes on to the next address without another 0 bit. The address wraps from the top of the array to 0.
- R5: Wide word a occupies narrow bytes 2a (upper half) and 2a+1 (lower half).
- R6: After reset, programming is locked, every stored bit is 1, and the output is disabled.
- R7: While programming is locked, write, erase, erase-all and fill-all are shifted in fully. They change no stored bit and start no program cycle. Read works whether programming is locked or unlocked.
- R8: Erase sets the addressed location to all ones and erase-all sets every location to all ones. Write stores the shifted data word and fill-all stores it in every location. Neither needs an erase first.
- R9: A program cycle starts on the last data bit (write, fill-all) or the last address bit (erase, erase-all) and lasts `PROG_CYCLES` system clocks. If select falls and then rises during the cycle, the output is enabled and shows 0 until the cycle ends and 1 after it ends, until select falls. If select rises only after the cycle has ended, the output stays disabled.
- R10: The output is disabled while select is low, once the synchronizer latency has passed.
- R11: Shift-clock edges that arrive during a program cycle are ignored.
- R12: If select falls before an instruction is complete, the instruction is dropped with no effect on the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus select, active high, asynchronous |
| sclk_i | input | 1 | Bus shift clock, asynchronous |
| sdin_i | input | 1 | Serial data from the host |
| wide_i | input | 1 | Organization strap: 1 = 64 x 16, 0 = 128 x 8 |
| sdout_o | output | 1 | Serial data / ready-busy flag to the host |
| sdout_en_o | output | 1 | Output enable; 0 means high impedance |

## Verification
The assertions check several properties on every cycle:

- the output stays disabled once select has been low for two cycles;
- the storage is never written while programming is locked or while a program cycle is already running;
- the first bit of every read is 0;
- the cycle timer never overruns and is never restarted while it is running.

Other behaviour can only be shown by the bench's scenarios. These are the opcode decoding, the contents read back after narrow and wide sweeps, the byte layout of wide words, address wrap during a continued read, and the busy-then-ready sequence. The same applies to abandoning an instruction part way through and to shift-clock edges that arrive while a cycle is running.

// File: rtl/sep_pkg.sv
package sep_pkg;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for select to rise
        ST_HUNT = 3'd1,   // select high, looking for the start bit
        ST_HDR  = 3'd2,   // shifting opcode and address
        ST_DATA = 3'd3,   // shifting write data
        ST_READ = 3'd4,   // driving read data
        ST_BUSY = 3'd5,   // self-timed program cycle
        ST_RDY  = 3'd6,   // showing the ready flag
        ST_WAIT = 3'd7    // instruction done, waiting for select low
    } sep_state_e;

    // Two-bit opcode that follows the start bit.
    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } sep_op_e;

    // Special actions, taken from the two top address bits.
    localparam logic [1:0] SUB_LOCK    = 2'b00;
    localparam logic [1:0] SUB_FILL    = 2'b01;
    localparam logic [1:0] SUB_ALLONES = 2'b10;
    localparam logic [1:0] SUB_UNLOCK  = 2'b11;

endpackage

// File: rtl/sep_sync.sv
module sep_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] stg_q [STAGES];
    logic [N-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg_q[STAGES-1];
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign rise_o = stg_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/sep_ptimer.sv
module sep_ptimer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)         cnt_d = LOAD;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != 0);

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/sep_array.sv
module sep_array #(
    parameter int NBYTES = 128,
    parameter int AW     = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_i,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic          all_i,
    input  logic [15:0]   wdata_i,
    output logic [15:0]   rdata_o
);

    logic [7:0]    mem_q [NBYTES];
    logic [7:0]    mem_d [NBYTES];
    logic [AW-1:0] hi_idx, lo_idx;

    // A wide word is an even byte (upper half) and the odd byte above it.
    assign hi_idx  = {addr_i[AW-2:0], 1'b0};
    assign lo_idx  = {addr_i[AW-2:0], 1'b1};
    assign rdata_o = wide_i ? {mem_q[hi_idx], mem_q[lo_idx]} : {8'h00, mem_q[addr_i]};

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            if (all_i) begin
                for (int i = 0; i < NBYTES; i++) begin
                    mem_d[i] = (wide_i && (i % 2 == 0)) ? wdata_i[15:8] : wdata_i[7:0];
                end
            end else if (wide_i) begin
                mem_d[hi_idx] = wdata_i[15:8];
                mem_d[lo_idx] = wdata_i[7:0];
            end else begin
                mem_d[addr_i] = wdata_i[7:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/sep_eeprom.sv
module sep_eeprom
    import sep_pkg::*;
#(
    parameter int MEM_BITS    = 1024,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdin_i,
    input  logic wide_i,
    output logic sdout_o,
    output logic sdout_en_o
);

    localparam int NBYTES = MEM_BITS / 8;
    localparam int AW     = $clog2(NBYTES);
    localparam int HW     = AW + 2;
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        sep_state_e  st;
        logic [HW-1:0] hdr;
        logic [4:0]  cnt;
        logic [15:0] sh;
        logic [AW-1:0] addr;
        sep_op_e     op;
        logic        pen;
        logic        stat;
        logic        dout;
    } ctl_t;

    localparam ctl_t RESET_C = '{st: ST_IDLE, hdr: '0, cnt: '0, sh: '0, addr: '0,
                                 op: OP_SPECIAL, pen: 1'b0, stat: 1'b0, dout: 1'b0};

    ctl_t r_d, r_q;

    // Synchronized bus lines
    logic [2:0] bus_lvl, bus_rise, bus_fall;
    logic sel_s, sel_rise, sel_fall, sk_rise, din;

    sep_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sdin_i, sclk_i, sel_i}),
        .lvl_o  (bus_lvl),
        .rise_o (bus_rise),
        .fall_o (bus_fall)
    );

    assign sel_s    = bus_lvl[0];
    assign sel_rise = bus_rise[0];
    assign sel_fall = bus_fall[0];
    assign sk_rise  = bus_rise[1];
    assign din      = bus_lvl[2];

    // Storage and program timer
    logic          arr_we, arr_all, tmr_start, tmr_busy;
    logic [15:0]   arr_wdata, arr_rdata;
    logic [AW-1:0] arr_addr;

    sep_array #(.NBYTES(NBYTES), .AW(AW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_i  (wide_i),
        .addr_i  (arr_addr),
        .we_i    (arr_we),
        .all_i   (arr_all),
        .wdata_i (arr_wdata),
        .rdata_o (arr_rdata)
    );

    sep_ptimer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (tmr_busy)
    );

    // Values as they would be after the bit now arriving is shifted in
    logic [4:0]    nw, nhdr;
    logic [HW-1:0] hdr_n;
    sep_op_e       op_n;
    logic [AW-1:0] addr_n, addr_inc;
    logic [1:0]    sub_n;
    logic [15:0]   dsh_n;

    assign nw     = wide_i ? 5'd16 : 5'd8;
    assign nhdr   = wide_i ? 5'(HW - 1) : 5'(HW);
    assign hdr_n  = {r_q.hdr[HW-2:0], din};
    assign op_n   = sep_op_e'(wide_i ? hdr_n[HW-2:HW-3] : hdr_n[HW-1:HW-2]);
    assign addr_n = wide_i ? {1'b0, hdr_n[AW-2:0]} : hdr_n[AW-1:0];
    assign sub_n  = wide_i ? hdr_n[AW-2:AW-3] : hdr_n[AW-1:AW-2];
    assign dsh_n  = {r_q.sh[14:0], din};
    assign addr_inc = wide_i ? {1'b0, r_q.addr[AW-2:0] + ONE[AW-2:0]} : r_q.addr + ONE;

    // Storage address: decoded address, next read address, or held address
    always_comb begin
        case (r_q.st)
            ST_HDR:  arr_addr = addr_n;
            ST_READ: arr_addr = addr_inc;
            default: arr_addr = r_q.addr;
        endcase
    end

    always_comb begin
        logic [15:0] word_c;
        r_d       = r_q;
        arr_we    = 1'b0;
        arr_all   = 1'b0;
        arr_wdata = '0;
        tmr_start = 1'b0;
        word_c    = r_q.sh;
        case (r_q.st)
            ST_IDLE: begin
                if (sel_rise) r_d.st = ST_HUNT;
            end
            ST_HUNT: begin
                if (!sel_s) r_d.st = ST_IDLE;
                else if (sk_rise && din) begin
                    r_d.st  = ST_HDR;
                    r_d.cnt = '0;
                    r_d.hdr = '0;
                end
            end
            ST_HDR: begin
                if (!sel_s) r_d.st = ST_IDLE;
                else if (sk_rise) begin
                    r_d.hdr = hdr_n;
                    r_d.cnt = r_q.cnt + 5'd1;
                    if (r_q.cnt + 5'd1 == nhdr) begin
                        r_d.cnt  = '0;
                        r_d.addr = addr_n;
                        r_d.op   = op_n;
                        r_d.st   = ST_WAIT;
                        case (op_n)
                            OP_READ: begin
                                r_d.st   = ST_READ;
                                r_d.sh   = arr_rdata;
                                r_d.cnt  = nw;
                                r_d.dout = 1'b0;
                            end
                            OP_WRITE: r_d.st = ST_DATA;
                            OP_ERASE: begin
                                if (r_q.pen) begin
                                    arr_we    = 1'b1;
                                    arr_wdata = '1;
                                    tmr_start = 1'b1;
                                    r_d.st    = ST_BUSY;
                                    r_d.stat  = 1'b0;
                                end
                            end
                            default: begin
                                case (sub_n)
                                    SUB_UNLOCK: r_d.pen = 1'b1;
                                    SUB_LOCK:   r_d.pen = 1'b0;
                                    SUB_FILL:   r_d.st  = ST_DATA;
                                    default: begin
                                        if (r_q.pen) begin
                                            arr_we    = 1'b1;
                                            arr_all   = 1'b1;
                                            arr_wdata = '1;
                                            tmr_start = 1'b1;
                                            r_d.st    = ST_BUSY;
                                            r_d.stat  = 1'b0;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
            end
            ST_DATA: begin
                if (!sel_s) r_d.st = ST_IDLE;
                else if (sk_rise) begin
                    r_d.sh  = dsh_n;
                    r_d.cnt = r_q.cnt + 5'd1;
                    if (r_q.cnt + 5'd1 == nw) begin
                        r_d.cnt = '0;
                        if (r_q.pen) begin
                            arr_we    = 1'b1;
                            arr_all   = (r_q.op == OP_SPECIAL);
                            arr_wdata = wide_i ? dsh_n : {8'h00, dsh_n[7:0]};
                            tmr_start = 1'b1;
                            r_d.st    = ST_BUSY;
                            r_d.stat  = 1'b0;
                        end else begin
                            r_d.st = ST_WAIT;
                        end
                    end
                end
            end
            ST_READ: begin
                if (!sel_s) r_d.st = ST_IDLE;
                else if (sk_rise) begin
                    if (r_q.cnt == 0) begin
                        word_c   = arr_rdata;
                        r_d.addr = addr_inc;
                        r_d.cnt  = nw - 5'd1;
                    end else begin
                        word_c  = r_q.sh;
                        r_d.cnt = r_q.cnt - 5'd1;
                    end
                    r_d.dout = wide_i ? word_c[15] : word_c[7];
                    r_d.sh   = {word_c[14:0], 1'b0};
                end
            end
            ST_BUSY: begin
                if (sel_fall)      r_d.stat = 1'b0;
                else if (sel_rise) r_d.stat = 1'b1;
                if (!tmr_busy) begin
                    if (!sel_s)        r_d.st = ST_IDLE;
                    else if (r_d.stat) r_d.st = ST_RDY;
                    else               r_d.st = ST_WAIT;
                end
            end
            ST_RDY, ST_WAIT: begin
                if (!sel_s) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_C;
        else        r_q <= r_d;
    end

    assign sdout_en_o = (r_q.st == ST_READ) || (r_q.st == ST_BUSY && r_q.stat) || (r_q.st == ST_RDY);
    assign sdout_o    = (r_q.st == ST_READ) ? r_q.dout : (r_q.st == ST_RDY);

    // R10
    hiz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && $past(!sel_s)) |-> !sdout_en_o);

    // R7
    wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> r_q.pen);

    // R3
    dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_READ && $past(r_q.st) != ST_READ) |-> (sdout_en_o && !sdout_o));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && $past(r_q.st) == ST_BUSY) |-> !arr_we);

endmodule

// File: tb/sep_eeprom_bench.sv
module sep_eeprom_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 60;
    localparam int HALF       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, wide = 1'b0;
    logic sdout, sdout_en;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit pen_m = 1'b0;
    logic [7:0] m [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    sep_eeprom #(.PROG_CYCLES(PROG)) u_sep_eeprom (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .sclk_i     (sclk),
        .sdin_i     (sdin),
        .wide_i     (wide),
        .sdout_o    (sdout),
        .sdout_en_o (sdout_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sdin = b;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
    endtask

    task automatic sel_up();
        sel = 1'b1;
        tick(HALF);
    endtask

    task automatic sel_dn();
        sel = 1'b0;
        tick(HALF);
    endtask

    // R1: a leading zero, start bit, opcode, address MSB first
    task automatic hdr(input logic w, input logic [1:0] op, input int a);
        wide = w;
        sel_up();
        sbit(1'b0);
        sbit(1'b1);
        sbit(op[1]);
        sbit(op[0]);
        for (int i = (w ? 5 : 6); i >= 0; i--) sbit(a[i]);
    endtask

    function automatic logic [15:0] expw(input logic w, input int a);
        return w ? {m[2*a], m[2*a+1]} : {8'h00, m[a]};
    endfunction

    task automatic shift_data(input logic w, input logic [15:0] d);
        for (int i = (w ? 15 : 7); i >= 0; i--) sbit(d[i]);
    endtask

    task automatic prog_wait();
        sel_dn();
        tick(PROG + 8);
    endtask

    task automatic model_wr(input logic w, input int a, input logic [15:0] d);
        if (w) begin
            m[2*a]   = d[15:8];
            m[2*a+1] = d[7:0];
        end else begin
            m[a] = d[7:0];
        end
    endtask

    task automatic wr(input logic w, input int a, input logic [15:0] d);
        hdr(w, 2'b01, a);
        shift_data(w, d);
        prog_wait();
        if (pen_m) model_wr(w, a, d);
    endtask

    task automatic erase1(input logic w, input int a);
        hdr(w, 2'b11, a);
        prog_wait();
        if (pen_m) model_wr(w, a, 16'hFFFF);
    endtask

    task automatic special(input logic w, input logic [1:0] sub);
        hdr(w, 2'b00, w ? (int'(sub) << 4) : (int'(sub) << 5));
    endtask

    task automatic rd(input logic w, input int a, input int n, input string req);
        hdr(w, 2'b10, a);
        chk({req, " lead-zero"}, {30'd0, sdout_en, sdout}, 32'h2);
        for (int k = 0; k < n; k++) begin
            logic [15:0] got = '0;
            for (int i = 0; i < (w ? 16 : 8); i++) begin
                sbit(1'b0);
                got = {got[14:0], sdout};
            end
            chk(req, {16'd0, got}, {16'd0, expw(w, (a + k) % (w ? 64 : 128))});
        end
        sel_dn();
        chk("R10 output off after read", {31'd0, sdout_en}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) m[i] = 8'hFF;
        tick(5);
        chk("R6 output disabled in reset", {31'd0, sdout_en}, 32'd0);
        rst_n = 1'b1;
        tick(2);
        chk("R6 output disabled after reset", {31'd0, sdout_en}, 32'd0);
        rd(1'b0, 0, 4, "R6 erased after reset");

        // R7: locked writes, erases and fills do nothing
        wr(1'b0, 5, 16'h003C);
        sel_up();
        chk("R7 no status when locked", {31'd0, sdout_en}, 32'd0);
        sel_dn();
        special(1'b0, 2'b01);
        shift_data(1'b0, 16'h0000);
        prog_wait();
        rd(1'b0, 4, 3, "R7 locked write and fill ignored");

        // R2: unlock
        special(1'b0, 2'b11);
        sel_dn();
        pen_m = 1'b1;

        // R9: busy then ready status on address 0
        hdr(1'b0, 2'b01, 0);
        shift_data(1'b0, 16'h0007);
        sel_dn();
        sel_up();
        chk("R9 busy flag", {30'd0, sdout_en, sdout}, 32'h2);
        tick(PROG);
        chk("R9 ready flag", {30'd0, sdout_en, sdout}, 32'h3);
        sel_dn();
        chk("R10 output off after status", {31'd0, sdout_en}, 32'd0);
        model_wr(1'b0, 0, 16'h0007);

        // R8: narrow write sweep over every address
        for (int a = 1; a < 128; a++) wr(1'b0, a, 16'((a * 29 + 7) & 8'hFF));
        sel_up();
        chk("R9 no status after cycle ended", {31'd0, sdout_en}, 32'd0);
        sel_dn();
        rd(1'b0, 0, 129, "R8 R4 narrow sweep with wrap");

        // R5: wide writes, then wide and narrow views
        for (int k = 0; k < 16; k++) begin
            int a = 3 * k + 1;
            wr(1'b1, a, 16'((a * 16'h1357) ^ 16'hBEEF));
        end
        rd(1'b1, 0, 65, "R5 R4 wide sweep with wrap");
        rd(1'b0, 2, 4, "R5 narrow view of wide word");

        // R8: single erase in both views
        erase1(1'b0, 10);
        erase1(1'b1, 20);
        rd(1'b0, 9, 3, "R8 erase narrow");
        rd(1'b1, 19, 3, "R8 erase wide");

        // R11: shift-clock edges during a cycle are ignored
        hdr(1'b0, 2'b01, 7);
        shift_data(1'b0, 16'h0011);
        sel_dn();
        sel_up();
        sbit(1'b1); sbit(1'b1); sbit(1'b0); sbit(1'b0); sbit(1'b0);
        chk("R11 still busy after ignored edges", {30'd0, sdout_en, sdout}, 32'h2);
        tick(PROG);
        chk("R11 ready after ignored edges", {30'd0, sdout_en, sdout}, 32'h3);
        sel_dn();
        model_wr(1'b0, 7, 16'h0011);
        rd(1'b0, 6, 3, "R11 data intact");

        // R12: abandoned write
        hdr(1'b0, 2'b01, 9);
        sbit(1'b1); sbit(1'b0); sbit(1'b1);
        sel_dn();
        chk("R10 R12 output off after abort", {31'd0, sdout_en}, 32'd0);
        tick(PROG + 8);
        rd(1'b0, 9, 1, "R12 abandoned write");

        // R8: fill-all in wide view
        special(1'b1, 2'b01);
        shift_data(1'b1, 16'hA55A);
        prog_wait();
        for (int a = 0; a < 64; a++) model_wr(1'b1, a, 16'hA55A);
        rd(1'b1, 0, 64, "R8 fill-all");

        // R8: erase-all
        special(1'b0, 2'b10);
        prog_wait();
        for (int i = 0; i < 128; i++) m[i] = 8'hFF;
        rd(1'b0, 0, 128, "R8 erase-all");

        // R2 R7: lock, then attempted write
        special(1'b0, 2'b00);
        sel_dn();
        pen_m = 1'b0;
        wr(1'b0, 3, 16'h0000);
        erase1(1'b0, 3);
        rd(1'b0, 2, 3, "R2 R7 lock blocks write");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule